// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a software-serviced watchdog that counts cycles of a 14 MHz reference clock. Software arms it and picks a timeout through a control register. It then keeps the board alive by writing the retrigger register, with any value, before the countdown runs out. If the countdown reaches its end, the block raises a one-cycle reset request toward the board's reset controller. The counter then halts until software restarts it.

The host reaches both registers through an 8-bit index/data pair. A write with `host_sel` low loads the index. A write with `host_sel` high goes to the register that the index names. `host_rdata` always shows the register that the index names. A board strap can disable the watchdog so that it can never be armed. A lock bit keeps the control register across warm resets. A locked, armed watchdog that nobody services therefore pulls the board through reset after reset. Only a power-up reset clears the lock.

The timeout is 2^(BASE_EXP+div) reference cycles. With the default BASE_EXP of 19, that is about 37 ms at div 0, and each div step doubles it.

Top module: `wdog_timer`

## Requirements
- R1: After power-up reset (`por_n` low), the control register reads 0x00 and `rst_req` stays low.
- R2: Index 0x00 selects the control register and index 0x01 selects the retrigger register. Any other index reads 0x00. The control layout is: bit 0 arm, bits 3:1 divider `div`, bit 7 lock. Bits 6:4 read 0.
- R3: When a write that restarts the countdown lands on clock edge E, `rst_req` is high for the cycle that follows edge E + 2^(BASE_EXP+div).
- R4: While the watchdog is armed, a data write of any value at index 0x01 restarts the full countdown.
- R5: While the watchdog is not armed, a retrigger write changes nothing. No reset request follows and the control register keeps its value.
- R6: A reset request lasts one cycle. The counter then stays halted, with no further request, until the next restart.
- R7: While `strap_dis` is high, the arm bit is stored as 0 and reads 0, and `rst_req` never rises.
- R8: A warm reset (`sys_rst_n` low at an edge) clears the index to 0x00. It clears the control register only when the lock bit (bit 7) is 0. With the lock bit set, the control value is held and the countdown restarts from full.
- R9: A locked, armed watchdog that is never serviced issues a fresh request one timeout after every warm reset.
- R10: Any data write to the control register restarts the countdown, using the divider value just written.
- R11: A power-up reset clears the control register even when the lock bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 14 MHz reference clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst_n | input | 1 | Warm reset, synchronous, active low |
| strap_dis | input | 1 | Board strap; high keeps the watchdog disabled |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | 0 = index register, 1 = data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by the index |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The checker relies on several properties of the inputs. `por_n` is released only after the first edge has captured reset. Each host write is a single-cycle strobe. `sys_rst_n` is a clean synchronous level. Given those, a cleared arm, a reset or a restart in one cycle rules out a request in the next. The stimulus strobes `host_we` for exactly one cycle from tasks and changes the strap and reset pins only at falling edges. With BASE_EXP reduced to 4 for the bench, every divider setting the bench uses ends well inside the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DIV_W = 3;

  localparam logic [7:0] IDX_CTRL = 8'h00;
  localparam logic [7:0] IDX_KICK = 8'h01;

  typedef struct packed {
    logic             lock;
    logic [DIV_W-1:0] div;
    logic             arm;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_hostif.sv
module wdog_hostif
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       strap_dis,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output wdog_ctrl_t ctrl_q,
  output logic       ctrl_wr,
  output logic       kick_wr
);
  logic [7:0] idx_q;
  logic       data_wr;

  assign data_wr = host_we && host_sel && sys_rst_n;
  assign ctrl_wr = data_wr && (idx_q == IDX_CTRL);
  assign kick_wr = data_wr && (idx_q == IDX_KICK);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      idx_q  <= '0;
      ctrl_q <= '0;
    end else if (!sys_rst_n) begin
      idx_q <= '0;
      if (!ctrl_q.lock) ctrl_q <= '0;
    end else if (host_we && !host_sel) begin
      idx_q <= host_wdata;
    end else if (ctrl_wr) begin
      ctrl_q.lock <= host_wdata[7];
      ctrl_q.div  <= host_wdata[DIV_W:1];
      ctrl_q.arm  <= host_wdata[0] & ~strap_dis;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (idx_q == IDX_CTRL) begin
      host_rdata[7]       = ctrl_q.lock;
      host_rdata[DIV_W:1] = ctrl_q.div;
      host_rdata[0]       = ctrl_q.arm & ~strap_dis;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_EXP = 19,
  parameter int DIV_W    = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             lock,
  input  logic             run_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_div,
  output logic             expire
);
  localparam int CNT_W = BASE_EXP + (1 << DIV_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             halted_q;

  assign load_val = (CNT_W'(1) << (BASE_EXP + int'(load_div))) - CNT_W'(1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q    <= '0;
      halted_q <= 1'b1;
      expire   <= 1'b0;
    end else if (!sys_rst_n) begin
      cnt_q    <= load_val;
      halted_q <= ~lock;
      expire   <= 1'b0;
    end else if (restart) begin
      cnt_q    <= load_val;
      halted_q <= 1'b0;
      expire   <= 1'b0;
    end else if (run_en && !halted_q) begin
      if (cnt_q == '0) begin
        halted_q <= 1'b1;
        expire   <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 19
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       strap_dis,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       rst_req
);
  wdog_ctrl_t       ctrl_q;
  logic             ctrl_wr;
  logic             kick_wr;
  logic             run_en;
  logic             restart;
  logic [DIV_W-1:0] load_div;

  wdog_hostif u_host (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .strap_dis (strap_dis),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .ctrl_q    (ctrl_q),
    .ctrl_wr   (ctrl_wr),
    .kick_wr   (kick_wr)
  );

  assign run_en   = ctrl_q.arm & ~strap_dis;
  assign restart  = ctrl_wr | (kick_wr & run_en);
  assign load_div = ctrl_wr ? host_wdata[DIV_W:1] : ctrl_q.div;

  wdog_counter #(
    .BASE_EXP(BASE_EXP),
    .DIV_W   (DIV_W)
  ) u_cnt (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .lock     (ctrl_q.lock),
    .run_en   (run_en),
    .restart  (restart),
    .load_div (load_div),
    .expire   (rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       strap_dis,
  input logic       rst_req,
  input logic       run_en,
  input logic       restart,
  input logic [4:0] ctrl_q
);
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  // R7
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    strap_dis |=> !rst_req);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !run_en |=> !rst_req);

  // R3
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> !rst_req);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && ctrl_q[4]) |=> (ctrl_q == $past(ctrl_q)));

  // R8
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !ctrl_q[4]) |=> (ctrl_q == 5'd0));
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .sys_rst_n(sys_rst_n),
  .strap_dis(strap_dis),
  .rst_req  (rst_req),
  .run_en   (run_en),
  .restart  (restart),
  .ctrl_q   (ctrl_q)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int BEXP = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       strap_dis = 1'b0;
  logic       host_we = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       rst_req;

  int unsigned cyc = 0;
  int          vec = 0;
  int          bad = 0;
  int unsigned exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.BASE_EXP(BEXP)) u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .strap_dis(strap_dis),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rst_req(rst_req)
  );

  function automatic int unsigned tmo(input int d);
    return 1 << (BEXP + d);
  endfunction

  task automatic hw(input logic s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_we = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic drop_pending();
    if (exp_q.size() > 0) void'(exp_q.pop_back());
  endtask

  task automatic expect_at(input int d);
    exp_q.push_back(cyc + tmo(d));
  endtask

  task automatic warm_reset();
    @(negedge clk); sys_rst_n = 1'b0;
    @(posedge clk); #1; sys_rst_n = 1'b1;
  endtask

  task automatic check_val(input logic [7:0] act, input logic [7:0] exv, input string rq);
    vec++;
    if (act !== exv) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", rq, act, exv);
    end
  endtask

  task automatic check_rd(input logic [7:0] idx, input logic [7:0] exv, input string rq);
    hw(1'b0, idx);
    @(negedge clk);
    check_val(host_rdata, exv, rq);
  endtask

  task automatic check_drained(input string rq);
    vec++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s: actual %0d pending requests expected 0", rq, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor: every request must match the head of the scoreboard (R3, R6)
  always @(negedge clk) begin
    if (por_n && rst_req === 1'b1) begin
      vec++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6: actual request at cycle %0d expected none", cyc);
      end else begin
        int unsigned e;
        e = exp_q.pop_front();
        if (cyc != e) begin
          bad++;
          $display("FAIL R3: actual request at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check_val({7'd0, rst_req}, 8'h00, "R1 rst_req");
    check_rd(8'h00, 8'h00, "R1 ctrl");

    // R2: layout, reserved bits, other index
    hw(1'b1, 8'h74);
    check_rd(8'h00, 8'h04, "R2 ctrl");
    check_rd(8'h01, 8'h00, "R2 kick index");
    check_rd(8'h37, 8'h00, "R2 unused index");

    // R3 / R6: div 0 timeout, then halted
    hw(1'b0, 8'h00);
    hw(1'b1, 8'h01); expect_at(0);
    repeat (60) @(posedge clk);
    check_drained("R6");

    // R4: retrigger with arbitrary values
    hw(1'b1, 8'h03); expect_at(1);
    repeat (20) @(posedge clk);
    hw(1'b0, 8'h01);
    hw(1'b1, 8'hA5); drop_pending(); expect_at(1);
    repeat (20) @(posedge clk);
    hw(1'b1, 8'h00); drop_pending(); expect_at(1);
    repeat (50) @(posedge clk);
    check_drained("R4");

    // R10: control rewrite changes divider and restarts
    hw(1'b0, 8'h00);
    hw(1'b1, 8'h05); expect_at(2);
    repeat (30) @(posedge clk);
    hw(1'b1, 8'h01); drop_pending(); expect_at(0);
    repeat (30) @(posedge clk);
    check_drained("R10");

    // R5: disarmed, retrigger ignored
    hw(1'b1, 8'h00);
    hw(1'b0, 8'h01);
    hw(1'b1, 8'hFF);
    hw(1'b1, 8'h00);
    repeat (100) @(posedge clk);
    check_rd(8'h00, 8'h00, "R5");

    // R7: strap blocks arming
    @(negedge clk); strap_dis = 1'b1;
    hw(1'b1, 8'h01);
    check_rd(8'h00, 8'h00, "R7");
    hw(1'b0, 8'h01);
    hw(1'b1, 8'h11);
    repeat (100) @(posedge clk);
    @(negedge clk); strap_dis = 1'b0;
    check_rd(8'h00, 8'h00, "R7 after release");
    repeat (40) @(posedge clk);

    // R8: unlocked clears, locked holds and index clears
    hw(1'b1, 8'h0A);
    warm_reset();
    check_rd(8'h00, 8'h00, "R8 unlocked");
    hw(1'b1, 8'h8A);
    hw(1'b0, 8'h01);
    warm_reset();
    @(negedge clk);
    check_val(host_rdata, 8'h8A, "R8 locked");

    // R9: reset loop
    hw(1'b1, 8'h81); expect_at(0);
    for (int k = 0; k < 3; k++) begin
      while (rst_req !== 1'b1) @(negedge clk);
      warm_reset(); expect_at(0);
    end
    repeat (30) @(posedge clk);
    check_drained("R9");
    check_rd(8'h00, 8'h81, "R9 ctrl held");
    hw(1'b1, 8'h00);

    // R11: power-up reset overrides lock
    hw(1'b1, 8'h83); expect_at(1);
    repeat (10) @(posedge clk);
    @(negedge clk); por_n = 1'b0; drop_pending();
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    check_rd(8'h00, 8'h00, "R11");
    repeat (80) @(posedge clk);

    // R3: longer divider
    hw(1'b1, 8'h07); expect_at(3);
    repeat (150) @(posedge clk);
    check_drained("R3");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule